// File: doc/BRIEF.md
# Host interrupt request controller

This block drives the level-type interrupt request lines that a host sees from a host-interface peripheral with three output data channels. Channel 1 carries the two keyboard-style requests (IRQ1 and IRQ12). Channels 2 and 3 each carry an SMI request and four legacy lines (IRQ6, IRQ9, IRQ10, IRQ11). Channel 3 has a second SMI source tied to a separate auxiliary data word. Each request source has its own enable bit, and the block stores that bit. The stored bit is the request flag, and the local CPU reads it back through `req_flags`.

A request is raised only by a handshake on the local CPU side. The CPU first reads the enable bit while it is 0, then writes 1 to it. For the keyboard requests, and for every other source while `dir_mode` is 0, that handshake must also come after a CPU write to the data word the source belongs to. A host read of that word then withdraws the request. While `dir_mode` is 1, channel 2 and 3 sources arm on the handshake alone, and host reads leave them alone. A CPU write of 0 always withdraws a request.

Source index map (LEG = 4): 0 IRQ1 and 1 IRQ12 (word 0); 2 SMI and 3..6 IRQ6/9/10/11 on channel 2 (word 1); 7 SMI on channel 3 (word 2); 8 SMI on the auxiliary word (word 3); 9..12 IRQ6/9/10/11 on channel 3 (word 2). Host line map: bit 0 IRQ1, bit 1 IRQ12, bit 2 SMI, bits 3..6 IRQ6/9/10/11.

Top module: `hirq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all request flags clear and all host lines drop. The read-as-0 and word-written tracking also clear, so after reset a read-0/write-1 handshake with no data word write does not set a keyboard request.
- R2: Sources 0 and 1 set one cycle after a write of 1 to their enable bit. This requires an earlier read of that bit as 0 and a write to data word 0 since that source's word was last consumed. This holds for either value of `dir_mode`.
- R3: A CPU write of 0 to an enable bit clears that request on the next edge in either mode. A host read of word 0 clears sources 0 and 1 in either mode.
- R4: With `dir_mode` 0, sources 2..12 set on the read-0/write-1 handshake only if their data word has been written since it was last consumed. Otherwise the write of 1 leaves the flag at 0.
- R5: With `dir_mode` 0, a host read of the data word of a source from 2..12 clears that request on the next edge.
- R6: With `dir_mode` 1, sources 2..12 set on the read-0/write-1 handshake with no data word write.
- R7: With `dir_mode` 1, host reads leave sources 2..12 unchanged. Only a CPU write of 0 clears them.
- R8: A write of 1 to an enable bit that has not been read as 0 since its last write leaves the flag unchanged. Any write to the bit consumes the read-as-0 mark.
- R9: When a set handshake and a clearing host read hit the same source in the same cycle, the flag ends at 0. The data word stays marked written.
- R10: A set that needed a data word consumes that word's written mark. A second handshake needs a new word write.
- R11: A host line is the OR of the flags of the sources mapped onto it, following the line map above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_mode | input | 1 | 1: channel 2/3 requests are handshake-only and ignore host reads |
| cpu_dwr_stb | input | NWORD (4) | CPU write strobe per data word |
| cpu_en_rd_mask | input | NSRC (13) | Enable bits covered by a CPU read this cycle |
| cpu_en_wr_mask | input | NSRC (13) | Enable bits covered by a CPU write this cycle |
| cpu_en_wr_data | input | NSRC (13) | Value written to each masked enable bit |
| host_rd_stb | input | NWORD (4) | Host read strobe per data word |
| req_flags | output | NSRC (13) | Request flag / enable bit per source |
| host_line | output | NLINE (7) | Host interrupt request lines |

## Verification
On every cycle the assertions check several properties. A flag only rises right after a write of 1 to its bit. A write of 0 always clears. Host reads clear the keyboard sources, and clear the channel 2/3 sources when `dir_mode` is 0. With `dir_mode` at 1, a pending channel 2/3 request holds until the CPU writes to it. Only the bench's scenarios can show the history-dependent rules, because they depend on what happened several cycles earlier. These are the read-as-0 mark, the consumption of a data word's written mark, the surviving word mark after a same-cycle collision, and the line map.

// File: rtl/hirq_pkg.sv
// Shared constants and source/word/line mapping for the host
// interrupt request controller. Assumes LEG legacy lines per channel.
package hirq_pkg;
    localparam int LEG_LINES = 4;
    localparam int NUM_WORDS = 4;

    // Number of request sources for a given legacy line count.
    function automatic int src_count(input int leg);
        return 5 + 2 * leg;
    endfunction

    // Number of host lines: IRQ1, IRQ12, SMI, then the legacy lines.
    function automatic int line_count(input int leg);
        return 3 + leg;
    endfunction

    // Data word that arms and host-clears a source.
    function automatic int word_of(input int s, input int leg);
        if (s < 2)            return 0;
        else if (s < 3 + leg) return 1;
        else if (s == 4 + leg) return 3;
        else                  return 2;
    endfunction

    // Keyboard sources behave the same in both modes.
    function automatic bit is_kbd(input int s);
        return s < 2;
    endfunction

    // Host line a source drives.
    function automatic int line_of(input int s, input int leg);
        if (s < 3)             return s;
        else if (s < 3 + leg)  return s;
        else if (s < 5 + leg)  return 2;
        else                   return s - 2 - leg;
    endfunction
endpackage

// File: rtl/hirq_arm_flag.sv
// Per-source "enable read as 0" mark. Set by a read while the flag is
// 0, consumed by any write to the bit (write takes priority).
module hirq_arm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_zero,
    input  logic wr_any,
    output logic armed
);
    // Track the read-as-0 mark until the next write to the bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (wr_any)  armed <= 1'b0;
        else if (rd_zero) armed <= 1'b1;
    end
endmodule

// File: rtl/hirq_word_flag.sv
// Per-data-word "written since last consumed" mark. A new CPU write
// wins over a consume in the same cycle.
module hirq_word_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic consume,
    output logic written
);
    // Hold the written mark until a set consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)       written <= 1'b0;
        else if (wr_stb)  written <= 1'b1;
        else if (consume) written <= 1'b0;
    end
endmodule

// File: rtl/hirq_req_cell.sv
// One request flag. Clear causes beat the set handshake. Assumes the
// caller has already qualified host_clr and word_ok by mode.
module hirq_req_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic wr_one,
    input  logic wr_zero,
    input  logic word_ok,
    input  logic host_clr,
    output logic req,
    output logic fire
);
    logic clr;

    // Any clear cause in this cycle.
    assign clr  = wr_zero | host_clr;
    // Set handshake completes, unless a clear collides with it.
    assign fire = wr_one & armed & word_ok & ~clr;

    // Request flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)    req <= 1'b0;
        else if (clr)  req <= 1'b0;
        else if (fire) req <= 1'b1;
    end
endmodule

// File: rtl/hirq_ctrl.sv
// Host interrupt request controller top. Builds one arm mark and one
// request cell per source, one written mark per data word, and ORs
// flags onto host lines. Assumes CPU and host strobes are one cycle.
module hirq_ctrl #(
    parameter int LEG   = hirq_pkg::LEG_LINES,
    parameter int NWORD = hirq_pkg::NUM_WORDS,
    parameter int NSRC  = hirq_pkg::src_count(LEG),
    parameter int NLINE = hirq_pkg::line_count(LEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_mode,
    input  logic [NWORD-1:0] cpu_dwr_stb,
    input  logic [NSRC-1:0]  cpu_en_rd_mask,
    input  logic [NSRC-1:0]  cpu_en_wr_mask,
    input  logic [NSRC-1:0]  cpu_en_wr_data,
    input  logic [NWORD-1:0] host_rd_stb,
    output logic [NSRC-1:0]  req_flags,
    output logic [NLINE-1:0] host_line
);
    logic [NSRC-1:0]  armed;
    logic [NSRC-1:0]  fire;
    logic [NSRC-1:0]  took_word;
    logic [NWORD-1:0] written;
    logic [NWORD-1:0] consume;

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        hirq_word_flag u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (cpu_dwr_stb[w]),
            .consume (consume[w]),
            .written (written[w])
        );
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam int W   = hirq_pkg::word_of(s, LEG);
        localparam bit KBD = hirq_pkg::is_kbd(s);
        logic need_word;

        // Word arming and host clearing apply to keyboard sources always,
        // and to the others only in mode 0.
        assign need_word = KBD | ~dir_mode;

        hirq_arm_flag u_arm (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_zero (cpu_en_rd_mask[s] & ~req_flags[s]),
            .wr_any  (cpu_en_wr_mask[s]),
            .armed   (armed[s])
        );

        hirq_req_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .armed    (armed[s]),
            .wr_one   (cpu_en_wr_mask[s] & cpu_en_wr_data[s]),
            .wr_zero  (cpu_en_wr_mask[s] & ~cpu_en_wr_data[s]),
            .word_ok  (~need_word | written[W]),
            .host_clr (need_word & host_rd_stb[W]),
            .req      (req_flags[s]),
            .fire     (fire[s])
        );

        // A set that relied on the word consumes its written mark.
        assign took_word[s] = fire[s] & need_word;
    end

    // Gather word consumption from every source mapped to each word.
    always_comb begin
        consume = '0;
        for (int s = 0; s < NSRC; s++) begin
            for (int w = 0; w < NWORD; w++) begin
                if (hirq_pkg::word_of(s, LEG) == w && took_word[s]) consume[w] = 1'b1;
            end
        end
    end

    // OR source flags onto the host lines.
    always_comb begin
        host_line = '0;
        for (int s = 0; s < NSRC; s++) begin
            for (int l = 0; l < NLINE; l++) begin
                if (hirq_pkg::line_of(s, LEG) == l && req_flags[s]) host_line[l] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hirq_ctrl_chk.sv
// Assertion checker for hirq_ctrl, bound to every instance. Observes
// ports only; assumes the source/word map from hirq_pkg.
module hirq_ctrl_chk #(
    parameter int LEG   = hirq_pkg::LEG_LINES,
    parameter int NWORD = hirq_pkg::NUM_WORDS,
    parameter int NSRC  = hirq_pkg::src_count(LEG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dir_mode,
    input logic [NSRC-1:0]  cpu_en_wr_mask,
    input logic [NSRC-1:0]  cpu_en_wr_data,
    input logic [NWORD-1:0] host_rd_stb,
    input logic [NSRC-1:0]  req_flags
);
    for (genvar s = 0; s < NSRC; s++) begin : g_chk
        localparam int W = hirq_pkg::word_of(s, LEG);

        assert_rise_needs_write1_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_flags[s]) |-> $past(cpu_en_wr_mask[s] & cpu_en_wr_data[s]));

        assert_write0_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_en_wr_mask[s] && !cpu_en_wr_data[s]) |=> !req_flags[s]);

        if (hirq_pkg::is_kbd(s)) begin : g_kbd
            assert_kbd_host_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
                host_rd_stb[W] |=> !req_flags[s]);
        end else begin : g_chan
            assert_mode0_host_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!dir_mode && host_rd_stb[W]) |=> !req_flags[s]);

            assert_mode1_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (dir_mode && !cpu_en_wr_mask[s] && req_flags[s]) |=> req_flags[s]);
        end
    end
endmodule

bind hirq_ctrl hirq_ctrl_chk #(.LEG(LEG), .NWORD(NWORD), .NSRC(NSRC)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .dir_mode       (dir_mode),
    .cpu_en_wr_mask (cpu_en_wr_mask),
    .cpu_en_wr_data (cpu_en_wr_data),
    .host_rd_stb    (host_rd_stb),
    .req_flags      (req_flags)
);

// File: tb/hirq_ctrl_tb_top.sv
// Bench for hirq_ctrl: behavioural per-cycle model compared on every
// falling edge, plus directed scenario checks with fixed expectations.
module hirq_ctrl_tb_top;
    localparam int LEG = 4;
    localparam int NS  = 5 + 2 * LEG;
    localparam int NW  = 4;
    localparam int NL  = 3 + LEG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dir_mode = 1'b0;
    logic [NW-1:0] cpu_dwr_stb = '0;
    logic [NS-1:0] cpu_en_rd_mask = '0;
    logic [NS-1:0] cpu_en_wr_mask = '0;
    logic [NS-1:0] cpu_en_wr_data = '0;
    logic [NW-1:0] host_rd_stb = '0;
    logic [NS-1:0] req_flags;
    logic [NL-1:0] host_line;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    live = 0;
    string tag = "R1";

    bit m_req [NS];
    bit m_arm [NS];
    bit m_wr  [NW];

    always #4 clk = ~clk;

    hirq_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .dir_mode       (dir_mode),
        .cpu_dwr_stb    (cpu_dwr_stb),
        .cpu_en_rd_mask (cpu_en_rd_mask),
        .cpu_en_wr_mask (cpu_en_wr_mask),
        .cpu_en_wr_data (cpu_en_wr_data),
        .host_rd_stb    (host_rd_stb),
        .req_flags      (req_flags),
        .host_line      (host_line)
    );

    function automatic int wmap(input int s);
        case (s)
            0, 1:              return 0;
            2, 3, 4, 5, 6:     return 1;
            8:                 return 3;
            default:           return 2;
        endcase
    endfunction

    function automatic int lmap(input int s);
        case (s)
            0: return 0;
            1: return 1;
            2, 7, 8: return 2;
            default: return (s < 7) ? s : s - 6;
        endcase
    endfunction

    // Reference model: next state from this edge's inputs.
    always @(posedge clk) begin
        bit nreq [NS];
        bit narm [NS];
        bit used [NW];
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin m_req[s] = 0; m_arm[s] = 0; end
            for (int w = 0; w < NW; w++) m_wr[w] = 0;
        end else begin
            for (int w = 0; w < NW; w++) used[w] = 0;
            for (int s = 0; s < NS; s++) begin
                bit kb, needw, one, zero, hclr, fire;
                int w;
                w     = wmap(s);
                kb    = (s < 2);
                needw = kb || !dir_mode;
                one   = cpu_en_wr_mask[s] && cpu_en_wr_data[s];
                zero  = cpu_en_wr_mask[s] && !cpu_en_wr_data[s];
                hclr  = needw && host_rd_stb[w];
                fire  = one && m_arm[s] && (!needw || m_wr[w]) && !hclr && !zero;
                if (zero || hclr) nreq[s] = 0;
                else if (fire)    nreq[s] = 1;
                else              nreq[s] = m_req[s];
                if (cpu_en_wr_mask[s])                     narm[s] = 0;
                else if (cpu_en_rd_mask[s] && !m_req[s])   narm[s] = 1;
                else                                       narm[s] = m_arm[s];
                if (fire && needw) used[w] = 1;
            end
            for (int s = 0; s < NS; s++) begin m_req[s] = nreq[s]; m_arm[s] = narm[s]; end
            for (int w = 0; w < NW; w++) begin
                if (cpu_dwr_stb[w])  m_wr[w] = 1;
                else if (used[w])    m_wr[w] = 0;
            end
        end
    end

    // Per-cycle comparison of outputs against the model.
    always @(negedge clk) begin
        if (live) begin
            logic [NS-1:0] er;
            logic [NL-1:0] el;
            el = '0;
            for (int s = 0; s < NS; s++) begin
                er[s] = m_req[s];
                if (m_req[s]) el[lmap(s)] = 1'b1;
            end
            checks++;
            if (req_flags !== er || host_line !== el) begin
                errors++;
                $display("FAIL %s model: flags=%h lines=%h expected flags=%h lines=%h",
                         tag, req_flags, host_line, er, el);
            end
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] b(input int s);
        return NS'(1) << s;
    endfunction

    task automatic step(input logic [NS-1:0] rd, input logic [NS-1:0] wm,
                        input logic [NS-1:0] wd, input logic [NW-1:0] dw,
                        input logic [NW-1:0] hr);
        cpu_en_rd_mask = rd; cpu_en_wr_mask = wm; cpu_en_wr_data = wd;
        cpu_dwr_stb = dw; host_rd_stb = hr;
        @(negedge clk);
        cpu_en_rd_mask = '0; cpu_en_wr_mask = '0; cpu_en_wr_data = '0;
        cpu_dwr_stb = '0; host_rd_stb = '0;
    endtask

    task automatic rd(input int s); step(b(s), '0, '0, '0, '0); endtask
    task automatic w1(input int s); step('0, b(s), b(s), '0, '0); endtask
    task automatic w0(input int s); step('0, b(s), '0, '0, '0); endtask
    task automatic dwr(input int w); step('0, '0, '0, NW'(1) << w, '0); endtask
    task automatic hrd(input int w); step('0, '0, '0, '0, NW'(1) << w); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;
        tag = "R1";
        check("R1 flags after reset", 32'(req_flags), 0);
        check("R1 lines after reset", 32'(host_line), 0);
        rd(0); w1(0);
        check("R1 no word mark after reset", 32'(req_flags[0]), 0);

        tag = "R8";
        dwr(0); w1(0);
        check("R8 write 1 without read-0", 32'(req_flags[0]), 0);

        tag = "R2";
        rd(0); w1(0);
        check("R2 irq1 set", 32'(req_flags[0]), 1);
        check("R11 irq1 line", 32'(host_line[0]), 1);
        dir_mode = 1'b1;
        dwr(0); rd(1); w1(1);
        check("R2 irq12 set in mode 1", 32'(req_flags[1]), 1);

        tag = "R3";
        hrd(0);
        check("R3 host read clears irq1", 32'(req_flags[0]), 0);
        check("R3 host read clears irq12", 32'(req_flags[1]), 0);
        dwr(0); rd(0); w1(0);
        check("R3 irq1 set again", 32'(req_flags[0]), 1);
        w0(0);
        check("R3 write 0 clears irq1", 32'(req_flags[0]), 0);

        tag = "R4";
        dir_mode = 1'b0;
        rd(2); w1(2);
        check("R4 smi ch2 no word write", 32'(req_flags[2]), 0);
        dwr(1); rd(2); w1(2);
        check("R4 smi ch2 set after word write", 32'(req_flags[2]), 1);
        check("R11 smi line", 32'(host_line[2]), 1);

        tag = "R5";
        hrd(1);
        check("R5 host read clears smi ch2", 32'(req_flags[2]), 0);

        tag = "R6";
        dir_mode = 1'b1;
        rd(3); w1(3);
        check("R6 irq6 ch2 set without word write", 32'(req_flags[3]), 1);

        tag = "R7";
        hrd(1);
        check("R7 host read ignored in mode 1", 32'(req_flags[3]), 1);
        w0(3);
        check("R7 write 0 clears in mode 1", 32'(req_flags[3]), 0);

        tag = "R9";
        dir_mode = 1'b0;
        dwr(2); rd(9);
        step('0, b(9), b(9), '0, 4'b0100);
        check("R9 clear beats set", 32'(req_flags[9]), 0);
        rd(9); w1(9);
        check("R9 word mark kept after collision", 32'(req_flags[9]), 1);
        check("R11 irq6 line from ch3", 32'(host_line[3]), 1);

        tag = "R10";
        w0(9); rd(9); w1(9);
        check("R10 word mark consumed", 32'(req_flags[9]), 0);
        dwr(2); w1(9);
        check("R10 read mark consumed by write", 32'(req_flags[9]), 0);
        rd(9); w1(9);
        check("R10 set after fresh handshake", 32'(req_flags[9]), 1);

        tag = "R11";
        dwr(3); rd(8); w1(8);
        check("R11 aux smi line map", 32'(host_line), 32'h0C);
        dir_mode = 1'b1;
        rd(12); w1(12);
        check("R11 irq11 ch3 line map", 32'(host_line), 32'h4C);
        hrd(3);
        check("R7 aux word host read ignored", 32'(req_flags[8]), 1);

        @(negedge clk);
        live = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule